// File: doc/BRIEF.md
# Floating-Point Immediate Constant Unit

This execution unit serves two instructions that build floating-point constants in a 64-bit register without a memory load. A 32-bit instruction word carries a 16-bit immediate split across three separate fields. The unit collects those fields into one value and writes a double-precision result to the target register.

The "set" instruction treats the immediate as the top half of a single-precision value, with the bottom half zero, and widens it to double precision. The "fill" instruction reads the target register and narrows it to single precision. It then overwrites the low 16 bits of that single value with the immediate and widens the result back. A set followed by a fill to the same register builds any single-precision constant in two instructions.

The unit drives the register-file read index combinationally from the instruction and takes the read data on the same cycle. The write port outputs are registered one cycle after an accepted instruction. No flag or status state is touched by either instruction.

Top module: `fp_imm_unit`

## Requirements
- R1: Bit 31 of `in_insn` is the most significant bit. The target index is `in_insn[25:21]`, and `rf_rd_idx` follows it in the same cycle. The immediate is `{in_insn[15:6], in_insn[20:16], in_insn[0]}`, with the 10-bit field as the most significant part.
- R2: An instruction is accepted only when `in_valid` is high, `in_insn[31:26]` equals `PRI_OP`, and `in_insn[5:1]` equals `XO_MOVE` (set) or `XO_HALF` (fill). Any other input gives `wr_en` low on the next cycle.
- R3: For an accepted instruction, `wr_en`, `wr_idx` and `wr_data` appear on the cycle after the clock edge that captured it.
- R4: Set writes the double-precision form of the single value `{imm, 16'h0000}`. For example, 0x3F80 gives 0x3FF0000000000000, 0xBFC0 gives 0xBFF8000000000000, 0x3FFF gives 0x3FFFE00000000000 and 0x7FC0 gives 0x7FF8000000000000.
- R5: Widening a normal single adds 896 to its exponent and places its 23 fraction bits at the top of the 52-bit fraction, with zeros below.
- R6: A single with exponent 0xFF widens to exponent 0x7FF, keeping the sign and the fraction payload. For example, 0x7F80 gives 0x7FF0000000000000 and 0xFF80 gives 0xFFF0000000000000.
- R7: Zeros keep their sign: set with 0x0000 gives all zeros, and set with 0x8000 gives 0x8000000000000000.
- R8: A denormal single is normalized when widened. For example, set with 0x0001 (single 0x00010000) gives 0x37A0000000000000.
- R9: Fill writes the double form of `{narrow(read data)[31:16], imm}` back to the same index. For example, 0x3FF0000000000000 filled with 0x8000 gives 0x3FF0100000000000.
- R10: Narrowing keeps the sign and maps the exponent back. It truncates the fraction to 23 bits with no rounding. For example, 0x3FF0100000000FFF filled with 0x1234 gives 0x3FF0024680000000.
- R11: While `rst_n` is low, `wr_en` is low.
- R12: A double whose exponent lies in 874..896 narrows to a denormal single by shifting the significand right. For example, 0x3800000000000000 filled with 0x0001 gives 0x3800000040000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word is present |
| in_insn | input | 32 | Instruction word |
| rf_rd_idx | output | 5 | Register-file read index (target field) |
| rf_rd_data | input | 64 | Register-file read data for `rf_rd_idx` |
| wr_en | output | 1 | Register-file write enable |
| wr_idx | output | 5 | Register-file write index |
| wr_data | output | 64 | Double-precision result |

## Verification
The assertions assume that `rf_rd_data` is already valid in the cycle the instruction is presented. They also assume that `in_valid` and `in_insn` are held low and stable during reset. The bench keeps a model register file and drives the read data from it combinationally, indexed by `rf_rd_idx`. It changes inputs only on the falling clock edge and keeps `in_valid` low until reset has been released. Random register contents include arbitrary 64-bit patterns, so out-of-range doubles reach the narrowing logic. The bench model follows the same bit-selection rule for those values.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
  localparam int INSN_W     = 32;
  localparam int REG_W      = 5;
  localparam int IMM_W      = 16;
  localparam int SP_W       = 32;
  localparam int DP_W       = 64;
  localparam int SP_EXP_W   = 8;
  localparam int SP_FRAC_W  = 23;
  localparam int DP_EXP_W   = 11;
  localparam int DP_FRAC_W  = 52;
  localparam int FRAC_PAD   = DP_FRAC_W - SP_FRAC_W;
  localparam int BIAS_DIFF  = 896;
  localparam int DENORM_LO  = BIAS_DIFF - SP_FRAC_W + 1;
  localparam int LZ_W       = 5;

  typedef enum logic [1:0] {OP_NONE, OP_SET, OP_FILL} op_e;

  typedef struct packed {
    op_e              op;
    logic [REG_W-1:0] tgt;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/fpimm_decode.sv
module fpimm_decode
  import fpimm_pkg::*;
#(
  parameter logic [5:0] PRI_OP  = 6'd22,
  parameter logic [4:0] XO_MOVE = 5'd24,
  parameter logic [4:0] XO_HALF = 5'd26
) (
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic [5:0] po;
  logic [4:0] xo;

  always_comb begin
    po      = insn[31:26];
    xo      = insn[5:1];
    dec.tgt = insn[25:21];
    dec.imm = {insn[15:6], insn[20:16], insn[0]};
    if (po != PRI_OP)       dec.op = OP_NONE;
    else if (xo == XO_MOVE) dec.op = OP_SET;
    else if (xo == XO_HALF) dec.op = OP_FILL;
    else                    dec.op = OP_NONE;
  end
endmodule

// File: rtl/fpimm_narrow.sv
module fpimm_narrow
  import fpimm_pkg::*;
(
  input  logic [DP_W-1:0] dp,
  output logic [SP_W-1:0] sp
);
  logic [DP_EXP_W-1:0]  ex;
  logic [DP_EXP_W-1:0]  sh;
  logic [SP_FRAC_W:0]   sig;

  always_comb begin
    ex  = dp[62:52];
    sh  = DP_EXP_W'(BIAS_DIFF + 1) - ex;
    sig = {1'b1, dp[51:FRAC_PAD]} >> sh;
    if (ex >= DP_EXP_W'(DENORM_LO) && ex <= DP_EXP_W'(BIAS_DIFF))
      sp = {dp[63], {SP_EXP_W{1'b0}}, sig[SP_FRAC_W-1:0]};
    else
      sp = {dp[63], dp[62], dp[58:52], dp[51:FRAC_PAD]};
  end
endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen
  import fpimm_pkg::*;
(
  input  logic [SP_W-1:0] sp,
  output logic [DP_W-1:0] dp
);
  logic [SP_EXP_W-1:0]  e;
  logic [SP_FRAC_W-1:0] f;
  logic [SP_FRAC_W-1:0] fn;
  logic [LZ_W-1:0]      lz;
  logic                 seen;

  always_comb begin
    e    = sp[30:23];
    f    = sp[22:0];
    lz   = '0;
    seen = 1'b0;
    for (int i = SP_FRAC_W - 1; i >= 0; i--) begin
      if (!seen && f[i]) begin
        lz   = LZ_W'(SP_FRAC_W - 1 - i);
        seen = 1'b1;
      end
    end
    fn = f << (lz + LZ_W'(1));
    if (e == '1)
      dp = {sp[31], {DP_EXP_W{1'b1}}, f, {FRAC_PAD{1'b0}}};
    else if (e == '0 && f == '0)
      dp = {sp[31], {(DP_W-1){1'b0}}};
    else if (e == '0)
      dp = {sp[31], DP_EXP_W'(BIAS_DIFF) - DP_EXP_W'(lz), fn, {FRAC_PAD{1'b0}}};
    else
      dp = {sp[31], DP_EXP_W'(e) + DP_EXP_W'(BIAS_DIFF), f, {FRAC_PAD{1'b0}}};
  end
endmodule

// File: rtl/fp_imm_unit.sv
module fp_imm_unit
  import fpimm_pkg::*;
#(
  parameter logic [5:0] PRI_OP  = 6'd22,
  parameter logic [4:0] XO_MOVE = 5'd24,
  parameter logic [4:0] XO_HALF = 5'd26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  output logic [REG_W-1:0]  rf_rd_idx,
  input  logic [DP_W-1:0]   rf_rd_data,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_idx,
  output logic [DP_W-1:0]   wr_data
);
  dec_t             dec;
  logic [SP_W-1:0]  sp_cur;
  logic [SP_W-1:0]  sp_new;
  logic [DP_W-1:0]  dp_new;
  logic             accept;
  logic             wr_en_d;
  logic [REG_W-1:0] wr_idx_d;
  logic [DP_W-1:0]  wr_data_d;

  fpimm_decode #(.PRI_OP(PRI_OP), .XO_MOVE(XO_MOVE), .XO_HALF(XO_HALF)) u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  fpimm_narrow u_nar (.dp(rf_rd_data), .sp(sp_cur));
  fpimm_widen  u_wid (.sp(sp_new),     .dp(dp_new));

  assign rf_rd_idx = dec.tgt;

  always_comb begin
    if (dec.op == OP_SET) sp_new = {dec.imm, {(SP_W-IMM_W){1'b0}}};
    else                  sp_new = {sp_cur[SP_W-1:IMM_W], dec.imm};
    accept    = in_valid && (dec.op != OP_NONE);
    wr_en_d   = accept;
    wr_idx_d  = accept ? dec.tgt : wr_idx;
    wr_data_d = accept ? dp_new  : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= wr_en_d;
      wr_idx  <= wr_idx_d;
      wr_data <= wr_data_d;
    end
  end
endmodule

// File: rtl/fp_imm_unit_chk.sv
module fp_imm_unit_chk #(
  parameter logic [5:0] PRI_OP  = 6'd22,
  parameter logic [4:0] XO_MOVE = 5'd24,
  parameter logic [4:0] XO_HALF = 5'd26
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_insn,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic [63:0] wr_data
);
  logic is_set;
  logic po_ok;
  assign po_ok  = in_insn[31:26] == PRI_OP;
  assign is_set = in_valid && po_ok && in_insn[5:1] == XO_MOVE;

  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |-> !wr_en); // R11
  AST_WR_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid)); // R3
  AST_BAD_PO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !po_ok) |=> !wr_en); // R2
  AST_WR_IDX_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx == $past(in_insn[25:21])); // R1
  AST_SET_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(is_set)) |-> wr_data[44:0] == '0); // R4
  AST_SET_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(is_set)) |-> wr_data[63] == $past(in_insn[15])); // R7
endmodule

bind fp_imm_unit fp_imm_unit_chk #(.PRI_OP(PRI_OP), .XO_MOVE(XO_MOVE), .XO_HALF(XO_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/sim_fp_imm_unit.sv
`timescale 1ns/1ps
module sim_fp_imm_unit;
  localparam logic [5:0] PO  = 6'd22;
  localparam logic [4:0] XS  = 5'd24;
  localparam logic [4:0] XF  = 5'd26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [4:0]  rf_rd_idx;
  logic [63:0] rf_rd_data;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic [63:0] tb_rf [32];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always_comb rf_rd_data = tb_rf[rf_rd_idx];

  fp_imm_unit #(.PRI_OP(PO), .XO_MOVE(XS), .XO_HALF(XF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  function automatic logic [63:0] m_widen(logic [31:0] s);
    logic [7:0]  e = s[30:23];
    logic [23:0] m = {1'b0, s[22:0]};
    int ex = -126;
    if (e == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'b0};
    if (e == 0 && s[22:0] == 0) return {s[31], 63'b0};
    if (e == 0) begin
      while (!m[23]) begin m = m << 1; ex = ex - 1; end
      return {s[31], 11'(ex + 1023), m[22:0], 29'b0};
    end
    return {s[31], 11'(int'(e) - 127 + 1023), s[22:0], 29'b0};
  endfunction

  function automatic logic [31:0] m_narrow(logic [63:0] d);
    int x = int'(d[62:52]);
    logic [23:0] m = {1'b1, d[51:29]};
    if (x >= 874 && x <= 896) begin
      for (int k = 0; k < 897 - x; k++) m = m >> 1;
      return {d[63], 8'h00, m[22:0]};
    end
    return {d[63], d[62], d[58:52], d[51:29]};
  endfunction

  function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] t, logic [4:0] xo, logic [15:0] imm);
    return {po, t, imm[5:1], imm[15:6], xo, imm[0]};
  endfunction

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one instruction at a falling edge, check the result one edge later
  task automatic run(string req, bit v, logic [31:0] insn);
    logic [4:0]  t = insn[25:21];
    logic [15:0] imm = {insn[15:6], insn[20:16], insn[0]};
    bit acc = v && insn[31:26] == PO && (insn[5:1] == XS || insn[5:1] == XF);
    logic [63:0] exp;
    in_valid = v;
    in_insn  = insn;
    #1;
    chk({req, " R1 rd_idx"}, 64'(rf_rd_idx), 64'(t));
    if (insn[5:1] == XS) exp = m_widen({imm, 16'h0});
    else                 exp = m_widen({m_narrow(tb_rf[t])[31:16], imm});
    @(posedge clk);
    @(negedge clk);
    chk({req, " R2/R3 wr_en"}, 64'(wr_en), 64'(acc));
    if (acc) begin
      chk({req, " R1 wr_idx"}, 64'(wr_idx), 64'(t));
      chk({req, " data"}, wr_data, exp);
      tb_rf[t] = exp;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    for (int i = 0; i < 32; i++) tb_rf[i] = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset wr_en", 64'(wr_en), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R4 one",   1, mk(PO, 5'd4, XS, 16'h3F80)); chk("R4 one v",   wr_data, 64'h3FF0000000000000);
    run("R4 m1p5",  1, mk(PO, 5'd5, XS, 16'hBFC0)); chk("R4 m1p5 v",  wr_data, 64'hBFF8000000000000);
    run("R5 max",   1, mk(PO, 5'd6, XS, 16'h3FFF)); chk("R5 max v",   wr_data, 64'h3FFFE00000000000);
    run("R6 qnan",  1, mk(PO, 5'd7, XS, 16'h7FC0)); chk("R6 qnan v",  wr_data, 64'h7FF8000000000000);
    run("R6 pinf",  1, mk(PO, 5'd8, XS, 16'h7F80)); chk("R6 pinf v",  wr_data, 64'h7FF0000000000000);
    run("R6 ninf",  1, mk(PO, 5'd9, XS, 16'hFF80)); chk("R6 ninf v",  wr_data, 64'hFFF0000000000000);
    run("R7 pzero", 1, mk(PO, 5'd10, XS, 16'h0000)); chk("R7 pzero v", wr_data, 64'h0);
    run("R7 nzero", 1, mk(PO, 5'd11, XS, 16'h8000)); chk("R7 nzero v", wr_data, 64'h8000000000000000);
    run("R8 denorm", 1, mk(PO, 5'd12, XS, 16'h0001)); chk("R8 denorm v", wr_data, 64'h37A0000000000000);
    run("R9 set",   1, mk(PO, 5'd4, XS, 16'h3F80));
    run("R9 fill",  1, mk(PO, 5'd4, XF, 16'h8000)); chk("R9 fill v", wr_data, 64'h3FF0100000000000);
    tb_rf[13] = 64'h3FF0100000000FFF;
    run("R10 trunc", 1, mk(PO, 5'd13, XF, 16'h1234)); chk("R10 trunc v", wr_data, 64'h3FF0024680000000);
    tb_rf[14] = 64'h3800000000000000;
    run("R12 dnar", 1, mk(PO, 5'd14, XF, 16'h0001)); chk("R12 dnar v", wr_data, 64'h3800000040000000);
    run("R2 badpo", 1, mk(PO ^ 6'h01, 5'd4, XS, 16'h4000));
    run("R2 badxo", 1, mk(PO, 5'd4, 5'd3, 16'h4000));
    run("R2 novalid", 0, mk(PO, 5'd4, XS, 16'h4000));
    run("R2 reg kept", 1, mk(PO, 5'd4, XF, 16'h8000)); chk("R2 reg kept v", wr_data, 64'h3FF0100000000000);

    for (int i = 0; i < 32; i++)
      tb_rf[i] = ($urandom % 2) ? {$urandom, $urandom} : m_widen($urandom);
    for (int n = 0; n < 400; n++) begin
      int k = $urandom % 8;
      logic [5:0] po = (k == 6) ? PO ^ 6'(1 + $urandom % 63) : PO;
      logic [4:0] xo = (k < 3) ? XS : (k < 6) ? XF : (k == 7) ? 5'd3 : XS;
      run("R9 random", ($urandom % 5) != 0, mk(po, 5'($urandom), xo, 16'($urandom)));
    end

    done = 1;
    report();
    $finish;
  end
endmodule